// File: doc/BRIEF.md
# Deferred Section Retry Dispatcher

This block sits between a primary work queue and a pool of workers. Sections of work, each one or more beats long and framed by a first-beat and a last-beat flag, enter a primary FIFO and are handed to whichever worker is ready on the output handshake. A worker that finds the data for a section is not ready yet returns the whole section on a second input. That section goes into a separate side FIFO, never back into the primary one.

A release counter counts the sections that leave the primary FIFO. When it reaches a threshold that can be rewritten while the block runs, the oldest parked section goes to the next ready worker ahead of any primary work. The counter then starts again from zero. Both FIFOs report their fill level in beats.

Top module: `retry_dispatch`

## Requirements
- R1: Primary sections leave in arrival order. A section is emitted whole: once its first beat (out_sop=1) is offered, only beats of that same section follow, up to the beat with out_eop=1. An offered beat stays stable until out_ready accepts it.
- R2: A section pushed on the park input is emitted later with out_retry=1, with its beats and flags unchanged. Parked sections leave oldest first. Primary sections are emitted with out_retry=0.
- R3: def_ready is low while the side FIFO holds RETRY_DEPTH beats, and a refused beat is not stored. in_ready is low while the primary FIFO holds MAIN_DEPTH beats. A beat held on a refused input is accepted once space frees.
- R4: A parked section is released at the next section boundary once the release count is at or above the threshold. Before that it stays parked, and out_valid stays low if no primary section is waiting.
- R5: The threshold is 3 after reset. A write on thr_we changes it at run time for every later release decision.
- R6: The release count returns to zero when a parked section starts leaving. It does not advance for primary sections emitted while the side FIFO holds no complete section.
- R7: Emitting a parked section never advances the release count.
- R8: If a release is due at the same section boundary where a primary section is waiting, the parked section is emitted first and the primary section waits.
- R9: main_level and retry_level equal the number of beats held in each FIFO.
- R10: After reset both levels are zero, both input readies are high and out_valid is low. A section is not offered until its last beat has been stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_we | input | 1 | Threshold write strobe |
| thr_val | input | CNT_W | New release threshold |
| in_valid | input | 1 | Primary input beat valid |
| in_ready | output | 1 | Primary FIFO can accept |
| in_data | input | 8 | Primary beat payload |
| in_sop | input | 1 | Primary beat opens a section |
| in_eop | input | 1 | Primary beat closes a section |
| def_valid | input | 1 | Park input beat valid |
| def_ready | output | 1 | Side FIFO can accept |
| def_data | input | 8 | Park beat payload |
| def_sop | input | 1 | Park beat opens a section |
| def_eop | input | 1 | Park beat closes a section |
| out_valid | output | 1 | Beat offered to workers |
| out_ready | input | 1 | A worker takes the beat |
| out_data | output | 8 | Offered payload |
| out_sop | output | 1 | Offered beat opens a section |
| out_eop | output | 1 | Offered beat closes a section |
| out_retry | output | 1 | Offered beat comes from the side FIFO |
| main_level | output | $clog2(MAIN_DEPTH+1) | Primary FIFO fill in beats |
| retry_level | output | $clog2(RETRY_DEPTH+1) | Side FIFO fill in beats |

## Verification
The due release and a waiting primary section can meet at the same section boundary. The bench provokes this by filling the side FIFO with two parked sections and the primary FIFO with several sections of different lengths. It then drains with the worker always ready, under every threshold from 0 to 4. The emitted order is compared beat by beat with a release schedule computed in the bench: a parked section must win each tie, and after a release the count must start from zero. Sections still parked at the end must stay parked with out_valid low.

// File: rtl/rd_pkg.sv
package rd_pkg;

    localparam int DESC_W = 8;

    typedef struct packed {
        logic              sop;
        logic              eop;
        logic [DESC_W-1:0] data;
    } beat_t;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_MAIN  = 2'd1,
        SRC_RETRY = 2'd2
    } src_e;

    function automatic int ptr_bits(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/rd_section_fifo.sv
module rd_section_fifo
    import rd_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_valid,
    output logic             push_ready,
    input  beat_t            push_beat,
    input  logic             pop,
    output beat_t            head,
    output logic [LVL_W-1:0] level,
    output logic [LVL_W-1:0] sections
);
    localparam int PW = ptr_bits(DEPTH);

    beat_t            mem [DEPTH];
    logic [PW-1:0]    wr_q, rd_q;
    logic [LVL_W-1:0] cnt_q, sec_q;
    logic             push_fire, pop_fire;

    function automatic logic [PW-1:0] bump_ptr(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign push_ready = (cnt_q != LVL_W'(DEPTH));
    assign push_fire  = push_valid && push_ready;
    assign pop_fire   = pop && (cnt_q != '0);
    assign head       = mem[rd_q];
    assign level      = cnt_q;
    assign sections   = sec_q;

    always_ff @(posedge clk) begin
        if (push_fire) begin
            mem[wr_q] <= push_beat;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
            sec_q <= '0;
        end else begin
            if (push_fire) wr_q <= bump_ptr(wr_q);
            if (pop_fire)  rd_q <= bump_ptr(rd_q);
            cnt_q <= cnt_q + LVL_W'(push_fire) - LVL_W'(pop_fire);
            sec_q <= sec_q + LVL_W'(push_fire && push_beat.eop)
                           - LVL_W'(pop_fire && head.eop);
        end
    end

endmodule

// File: rtl/rd_release_counter.sv
module rd_release_counter #(
    parameter int CNT_W      = 4,
    parameter int THRESH_RST = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             thr_we,
    input  logic [CNT_W-1:0] thr_val,
    input  logic             bump,
    input  logic             clear,
    output logic             due
);
    logic [CNT_W-1:0] thr_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q <= CNT_W'(THRESH_RST);
        end else if (thr_we) begin
            thr_q <= thr_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (bump && (cnt_q != '1)) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign due = (cnt_q >= thr_q);

endmodule

// File: rtl/rd_source_arbiter.sv
module rd_source_arbiter
    import rd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  main_has_sec,
    input  logic  retry_has_sec,
    input  logic  release_due,
    input  beat_t main_head,
    input  beat_t retry_head,
    input  logic  out_ready,
    output logic  out_valid,
    output beat_t out_beat,
    output logic  out_retry,
    output logic  pop_main,
    output logic  pop_retry
);
    src_e lock_q, sel, lock_d;
    logic take;

    always_comb begin
        if (lock_q != SRC_NONE) begin
            sel = lock_q;
        end else if (retry_has_sec && release_due) begin
            sel = SRC_RETRY;
        end else if (main_has_sec) begin
            sel = SRC_MAIN;
        end else begin
            sel = SRC_NONE;
        end
    end

    assign out_valid = (sel != SRC_NONE);
    assign out_retry = (sel == SRC_RETRY);
    assign out_beat  = out_retry ? retry_head : main_head;
    assign take      = out_valid && out_ready;
    assign pop_main  = take && (sel == SRC_MAIN);
    assign pop_retry = take && (sel == SRC_RETRY);

    always_comb begin
        if (out_valid && !(take && out_beat.eop)) begin
            lock_d = sel;
        end else begin
            lock_d = SRC_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= SRC_NONE;
        end else begin
            lock_q <= lock_d;
        end
    end

endmodule

// File: rtl/retry_dispatch.sv
module retry_dispatch
    import rd_pkg::*;
#(
    parameter int MAIN_DEPTH  = 8,
    parameter int RETRY_DEPTH = 4,
    parameter int CNT_W       = 4,
    parameter int THRESH_RST  = 3
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               thr_we,
    input  logic [CNT_W-1:0]                   thr_val,
    input  logic                               in_valid,
    output logic                               in_ready,
    input  logic [DESC_W-1:0]                  in_data,
    input  logic                               in_sop,
    input  logic                               in_eop,
    input  logic                               def_valid,
    output logic                               def_ready,
    input  logic [DESC_W-1:0]                  def_data,
    input  logic                               def_sop,
    input  logic                               def_eop,
    output logic                               out_valid,
    input  logic                               out_ready,
    output logic [DESC_W-1:0]                  out_data,
    output logic                               out_sop,
    output logic                               out_eop,
    output logic                               out_retry,
    output logic [$clog2(MAIN_DEPTH+1)-1:0]    main_level,
    output logic [$clog2(RETRY_DEPTH+1)-1:0]   retry_level
);
    localparam int MLW = $clog2(MAIN_DEPTH + 1);
    localparam int RLW = $clog2(RETRY_DEPTH + 1);

    beat_t          main_in, retry_in, main_head, retry_head, out_beat;
    logic [MLW-1:0] main_secs;
    logic [RLW-1:0] retry_secs;
    logic           pop_main, pop_retry, due, bump, clear;

    assign main_in  = '{sop: in_sop,  eop: in_eop,  data: in_data};
    assign retry_in = '{sop: def_sop, eop: def_eop, data: def_data};

    rd_section_fifo #(.DEPTH(MAIN_DEPTH), .LVL_W(MLW)) u_main_fifo (
        .clk        (clk),
        .rst        (rst),
        .push_valid (in_valid),
        .push_ready (in_ready),
        .push_beat  (main_in),
        .pop        (pop_main),
        .head       (main_head),
        .level      (main_level),
        .sections   (main_secs)
    );

    rd_section_fifo #(.DEPTH(RETRY_DEPTH), .LVL_W(RLW)) u_retry_fifo (
        .clk        (clk),
        .rst        (rst),
        .push_valid (def_valid),
        .push_ready (def_ready),
        .push_beat  (retry_in),
        .pop        (pop_retry),
        .head       (retry_head),
        .level      (retry_level),
        .sections   (retry_secs)
    );

    // Count finished primary sections only while a parked section waits.
    assign bump  = pop_main && main_head.eop && (retry_secs != '0);
    assign clear = pop_retry && retry_head.sop;

    rd_release_counter #(.CNT_W(CNT_W), .THRESH_RST(THRESH_RST)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .thr_we  (thr_we),
        .thr_val (thr_val),
        .bump    (bump),
        .clear   (clear),
        .due     (due)
    );

    rd_source_arbiter u_arbiter (
        .clk           (clk),
        .rst           (rst),
        .main_has_sec  (main_secs != '0),
        .retry_has_sec (retry_secs != '0),
        .release_due   (due),
        .main_head     (main_head),
        .retry_head    (retry_head),
        .out_ready     (out_ready),
        .out_valid     (out_valid),
        .out_beat      (out_beat),
        .out_retry     (out_retry),
        .pop_main      (pop_main),
        .pop_retry     (pop_retry)
    );

    assign out_data = out_beat.data;
    assign out_sop  = out_beat.sop;
    assign out_eop  = out_beat.eop;

endmodule

// File: rtl/rd_checker.sv
module rd_checker #(
    parameter int MAIN_DEPTH  = 8,
    parameter int RETRY_DEPTH = 4,
    parameter int DW          = 8
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             in_valid,
    input logic                             in_ready,
    input logic                             def_valid,
    input logic                             def_ready,
    input logic                             out_valid,
    input logic                             out_ready,
    input logic [DW-1:0]                    out_data,
    input logic                             out_sop,
    input logic                             out_eop,
    input logic                             out_retry,
    input logic [$clog2(MAIN_DEPTH+1)-1:0]  main_level,
    input logic [$clog2(RETRY_DEPTH+1)-1:0] retry_level
);
    logic in_sec, sec_retry;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_sec    <= 1'b0;
            sec_retry <= 1'b0;
        end else if (out_valid && out_ready) begin
            in_sec    <= !out_eop;
            sec_retry <= out_retry;
        end
    end

    assert_hold_offer_R1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_retry)
                                       && $stable(out_sop) && $stable(out_eop)));

    assert_no_interleave_R1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && in_sec) |-> (!out_sop && (out_retry == sec_retry)));

    assert_section_start_R1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !in_sec) |-> out_sop);

    assert_refuse_keeps_R3: assert property (@(posedge clk) disable iff (rst)
        (def_valid && !def_ready && !(out_valid && out_ready && out_retry))
            |=> (retry_level == $past(retry_level)));

    assert_main_level_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (int'(main_level) == int'($past(main_level))
                         + int'($past(in_valid && in_ready))
                         - int'($past(out_valid && out_ready && !out_retry))));

    assert_retry_level_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (int'(retry_level) == int'($past(retry_level))
                         + int'($past(def_valid && def_ready))
                         - int'($past(out_valid && out_ready && out_retry))));

    assert_idle_empty_R10: assert property (@(posedge clk) disable iff (rst)
        ((main_level == '0) && (retry_level == '0)) |-> !out_valid);

endmodule

bind retry_dispatch rd_checker #(
    .MAIN_DEPTH  (MAIN_DEPTH),
    .RETRY_DEPTH (RETRY_DEPTH),
    .DW          (rd_pkg::DESC_W)
) u_rd_checker (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .def_valid   (def_valid),
    .def_ready   (def_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .out_sop     (out_sop),
    .out_eop     (out_eop),
    .out_retry   (out_retry),
    .main_level  (main_level),
    .retry_level (retry_level)
);

// File: tb/test_retry_dispatch.sv
module test_retry_dispatch;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       thr_we = 1'b0;
    logic [3:0] thr_val = '0;
    logic       in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0] in_data = '0;
    logic       def_valid = 1'b0, def_sop = 1'b0, def_eop = 1'b0;
    logic [7:0] def_data = '0;
    logic       out_ready = 1'b0;
    logic       in_ready, def_ready, out_valid, out_sop, out_eop, out_retry;
    logic [7:0] out_data;
    logic [3:0] main_level;
    logic [2:0] retry_level;

    int checks = 0;
    int fails  = 0;
    logic [10:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    retry_dispatch i_retry_dispatch (
        .clk(clk), .rst(rst), .thr_we(thr_we), .thr_val(thr_val),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop),
        .def_valid(def_valid), .def_ready(def_ready), .def_data(def_data),
        .def_sop(def_sop), .def_eop(def_eop),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop), .out_retry(out_retry),
        .main_level(main_level), .retry_level(retry_level)
    );

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0; def_valid = 1'b0; out_ready = 1'b0; thr_we = 1'b0;
        exp_q.delete();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic write_thr(input int t);
        thr_val = 4'(t);
        thr_we  = 1'b1;
        @(negedge clk);
        thr_we  = 1'b0;
    endtask

    function automatic logic [7:0] beat_data(input bit retry, input int tag, input int b);
        return {retry, 4'(tag), 3'(b)};
    endfunction

    task automatic push_beat(input bit retry, input bit s, input bit e, input logic [7:0] d);
        if (retry) begin
            def_valid = 1'b1; def_sop = s; def_eop = e; def_data = d;
            while (!def_ready) @(negedge clk);
            @(negedge clk);
            def_valid = 1'b0;
        end else begin
            in_valid = 1'b1; in_sop = s; in_eop = e; in_data = d;
            while (!in_ready) @(negedge clk);
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic push_section(input bit retry, input int tag, input int len);
        for (int b = 0; b < len; b++)
            push_beat(retry, b == 0, b == len - 1, beat_data(retry, tag, b));
    endtask

    task automatic expect_section(input bit retry, input int tag, input int len);
        for (int b = 0; b < len; b++)
            exp_q.push_back({retry, b == 0, b == len - 1, beat_data(retry, tag, b)});
    endtask

    task automatic drain(input string req);
        out_ready = 1'b1;
        forever begin
            if (exp_q.size() == 0) break;
            if (out_valid) begin
                chk(req, int'({out_retry, out_sop, out_eop, out_data}), int'(exp_q[0]));
                void'(exp_q.pop_front());
            end
            @(negedge clk);
        end
        out_ready = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R10: reset state
        do_reset();
        chk("R10 out_valid", int'(out_valid), 0);
        chk("R10 in_ready", int'(in_ready), 1);
        chk("R10 def_ready", int'(def_ready), 1);
        chk("R10 main_level", int'(main_level), 0);
        chk("R10 retry_level", int'(retry_level), 0);

        // R4 R5 R7 R8: threshold sweep, two parked and three primary sections
        for (int t = 0; t < 5; t++) begin
            int cnt, d, m, di, mi;
            do_reset();
            if (t != 3) write_thr(t);   // t==3 relies on the reset value (R5)
            push_section(1'b1, 0, 2);
            push_section(1'b1, 1, 2);
            for (int k = 0; k < 3; k++) push_section(1'b0, k, k + 1);
            chk("R9 main_level", int'(main_level), 6);
            chk("R9 retry_level", int'(retry_level), 4);
            cnt = 0; d = 2; m = 3; di = 0; mi = 0;
            forever begin
                if (d > 0 && cnt >= t) begin
                    expect_section(1'b1, di, 2); di++; d--; cnt = 0;
                end else if (m > 0) begin
                    expect_section(1'b0, mi, mi + 1); mi++; m--;
                    if (d > 0 && cnt < 15) cnt++;
                end else break;
            end
            drain((t == 3) ? "R5 R4 R8" : "R4 R7 R8 R2");
            repeat (3) @(negedge clk);
            chk("R4 parked stays", int'(out_valid), 0);
            chk("R4 retry_level left", int'(retry_level), d * 2);
            chk("R9 main_level empty", int'(main_level), 0);
        end

        // R6: no counting while nothing is parked
        do_reset();
        write_thr(2);
        for (int k = 0; k < 3; k++) push_section(1'b0, k, 1);
        for (int k = 0; k < 3; k++) expect_section(1'b0, k, 1);
        drain("R6 primary only");
        push_section(1'b1, 0, 2);
        for (int k = 3; k < 6; k++) push_section(1'b0, k, 1);
        expect_section(1'b0, 3, 1);
        expect_section(1'b0, 4, 1);
        expect_section(1'b1, 0, 2);
        expect_section(1'b0, 5, 1);
        drain("R6 hold then release");
        chk("R6 levels", int'(retry_level) + int'(main_level), 0);

        // R10: open section not offered
        do_reset();
        push_beat(1'b0, 1'b1, 1'b0, 8'h11);
        repeat (3) @(negedge clk);
        chk("R10 open section", int'(out_valid), 0);
        chk("R10 open level", int'(main_level), 1);
        push_beat(1'b0, 1'b0, 1'b1, 8'h12);
        exp_q.push_back({3'b010, 8'h11});
        exp_q.push_back({3'b001, 8'h12});
        drain("R10 R1 closed section");

        // R3: both FIFOs full, refused beats held
        do_reset();
        push_section(1'b1, 0, 2);
        push_section(1'b1, 1, 2);
        def_valid = 1'b1; def_sop = 1'b1; def_eop = 1'b1; def_data = 8'hEE;
        for (int i = 0; i < 3; i++) begin
            chk("R3 def_ready full", int'(def_ready), 0);
            @(negedge clk);
        end
        def_valid = 1'b0;
        chk("R3 retry_level kept", int'(retry_level), 4);
        for (int k = 0; k < 8; k++) push_section(1'b0, k, 1);
        chk("R3 in_ready full", int'(in_ready), 0);
        chk("R9 main_level full", int'(main_level), 8);
        begin
            int cnt, d, m, di, mi;
            cnt = 0; d = 2; m = 9; di = 0; mi = 0;
            forever begin
                if (d > 0 && cnt >= 3) begin
                    expect_section(1'b1, di, 2); di++; d--; cnt = 0;
                end else if (m > 0) begin
                    expect_section(1'b0, mi, 1); mi++; m--;
                    if (d > 0) cnt++;
                end else break;
            end
        end
        fork
            begin
                in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b1; in_data = beat_data(1'b0, 8, 0);
                while (!in_ready) @(negedge clk);
                @(negedge clk);
                in_valid = 1'b0;
            end
            drain("R3 held beat R8");
        join
        chk("R3 drained", int'(main_level) + int'(retry_level), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule